// File: doc/BRIEF.md
# Single-Shot Converter Control Register Block

This block is the register front of a multi-channel successive-approximation converter. Software reaches it through a word-addressed bus with single-cycle writes and combinational reads. It holds a control word, a channel/scale word, the latest sample, and a set of three interrupt registers: enable, raw and masked, plus a write-one-to-clear port. Setting the run bit starts a burst of conversions. The block sends a start strobe together with the selected channel and input scale. It then waits for the converter's done pulse and stores the 12-bit sample that comes with it.

After the last sample of the burst, the block clears the run bit and sets a raw completion flag. The raw flag is gated by the interrupt enable to drive the interrupt line. Software follows a fixed sequence:

1. Turn the converter on.
2. Clear any stale flag.
3. Program channel and scale.
4. Program the mode and the repeat count.
5. Set the run bit.
6. Poll the raw flag.
7. Read the sample.
8. Turn the converter off.

Turning the converter off during a burst abandons the burst.

Top module: `sadc_ctl_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is 0 and `cvt_start` is 0.
- R2: `bus_addr` is the byte offset divided by four. The word indices are: control 0, channel config 1, sample 19, interrupt enable 20, clear 21, masked status 22, raw status 23. Unmapped and write-only words read zero.
- R3: The control word has these fields: bit 0 converter on, bit 1 run, bit 2 wide (12-bit) mode, bits 7:4 repeat count. The wide bit drives `cvt_wide`. All other bits read zero.
- R4: The channel config word holds the channel in bits 4:0 and the scale in bits 10:9, and reads back those fields only. Every start strobe presents them on `cvt_chan` and `cvt_scale`.
- R5: With repeat count n, a run issues exactly n+1 single-cycle start strobes. The run bit then clears by itself, and the sample word holds the last sample.
- R6: The sample word returns the sample in bits 11:0 and zeros above.
- R7: Raw status bit 0 sets when a run completes. Writing 1 to clear bit 0 resets it.
- R8: Masked status bit 0 equals raw bit 0 AND interrupt-enable bit 0, and `irq` equals masked bit 0. The enable word reads back bit 0 only.
- R9: A write that sets the run bit while the converter-on bit is 0 (after that write) is ignored: no strobe is issued and run reads 0.
- R10: Clearing the converter-on bit during a run returns the block to idle. No further strobes are issued, the raw flag stays clear, and later done pulses do not change the sample.
- R11: A clear write in the same cycle as a completion leaves the raw flag set.
- R12: A done pulse that arrives while no conversion is awaited changes neither the sample nor the raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| cvt_start | output | 1 | One-cycle conversion start strobe |
| cvt_chan | output | 5 | Channel to sample |
| cvt_scale | output | 2 | Input scale to apply |
| cvt_wide | output | 1 | 12-bit mode select |
| cvt_done | input | 1 | Conversion complete pulse |
| cvt_sample | input | 12 | Sample valid with `cvt_done` |
| irq | output | 1 | Masked completion interrupt |

## Verification
A wrong sequencer state appears at the ports within one converter latency, as one of three faults:
- an extra or missing `cvt_start` strobe;
- a run bit that never clears;
- a raw flag that rises after an abort.

The bench counts strobes per run and watches the run bit and raw flag for tens of cycles after an abort. A wrong capture path shows up at the next read of the sample word, so every channel and scale pair is swept with a sample value that depends on channel, scale and strobe index.

// File: rtl/sadc_pkg.sv
// Shared register map, field positions and sequencer states for the
// converter control block. Assumes a 32-bit bus addressed by word index.
package sadc_pkg;
    localparam int ADDR_W = 6;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] W_CTRL = 6'd0;
    localparam logic [ADDR_W-1:0] W_CFG  = 6'd1;
    localparam logic [ADDR_W-1:0] W_DATA = 6'd19;
    localparam logic [ADDR_W-1:0] W_IEN  = 6'd20;
    localparam logic [ADDR_W-1:0] W_CLR  = 6'd21;
    localparam logic [ADDR_W-1:0] W_MSK  = 6'd22;
    localparam logic [ADDR_W-1:0] W_RAW  = 6'd23;

    localparam int B_ON     = 0;
    localparam int B_RUN    = 1;
    localparam int B_WIDE   = 2;
    localparam int B_CNT_LO = 4;
    localparam int B_CH_LO  = 0;
    localparam int B_SC_LO  = 9;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sadc_cfg_regs.sv
// Control and channel-configuration registers.
// Assumes: single-cycle writes; the sequencer reports burst completion
// with a one-cycle finish pulse. The run bit is set only by software and
// cleared by completion or by turning the converter off.
module sadc_cfg_regs
    import sadc_pkg::*;
#(
    parameter int CHAN_W  = 5,
    parameter int SCALE_W = 2,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               seq_finish,
    output logic               on_q,
    output logic               run_q,
    output logic               wide_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CHAN_W-1:0]  chan_q,
    output logic [SCALE_W-1:0] scale_q
);
    logic wr_ctrl, wr_cfg, on_next;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_ctrl      = we && (addr == W_CTRL);
    assign wr_cfg       = we && (addr == W_CFG);
    assign on_next      = wr_ctrl ? wdata[B_ON] : on_q;

    // Control fields: converter-on, mode and repeat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            wide_q <= 1'b0;
            cnt_q  <= '0;
        end else if (wr_ctrl) begin
            on_q   <= wdata[B_ON];
            wide_q <= wdata[B_WIDE];
            cnt_q  <= wdata[B_CNT_LO +: CNT_W];
        end
    end

    // Run bit: a software set needs the converter on; completion or power-off clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_ctrl && wdata[B_RUN] && on_next) begin
            run_q <= 1'b1;
        end else if (!on_next || seq_finish) begin
            run_q <= 1'b0;
        end
    end

    // Channel and scale selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            scale_q <= '0;
        end else if (wr_cfg) begin
            chan_q  <= wdata[B_CH_LO +: CHAN_W];
            scale_q <= wdata[B_SC_LO +: SCALE_W];
        end
    end

    assert_run_needs_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> on_q);
endmodule

// File: rtl/sadc_sequencer.sv
// Burst sequencer: issues one start strobe per sample, waits for the
// converter's done pulse, captures the sample, and counts down the
// repeat count. Assumes the converter answers each strobe at most once;
// done pulses outside the wait state are dropped.
module sadc_sequencer
    import sadc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                on,
    input  logic                run,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                cvt_done,
    input  logic [SAMPLE_W-1:0] cvt_sample,
    output logic                cvt_start,
    output logic                finish,
    output logic [SAMPLE_W-1:0] sample_q
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] left_q;
    logic             take;

    assign take      = (state_q == SQ_WAIT) && on && cvt_done;
    assign finish    = take && (left_q == '0);
    assign cvt_start = (state_q == SQ_ISSUE) && on;

    // State walk and remaining-sample count; power-off forces idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            left_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (run && on) begin
                    state_q <= SQ_ISSUE;
                    left_q  <= cnt;
                end
                SQ_ISSUE: state_q <= on ? SQ_WAIT : SQ_IDLE;
                SQ_WAIT: begin
                    if (!on) begin
                        state_q <= SQ_IDLE;
                    end else if (cvt_done) begin
                        if (left_q == '0) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            state_q <= SQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Sample capture on an awaited done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else if (take) begin
            sample_q <= cvt_sample;
        end
    end

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_start |=> !cvt_start);
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE && !on) |=> (state_q == SQ_IDLE));
    assert_idle_holds_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |=> $stable(sample_q));
endmodule

// File: rtl/sadc_irq_flag.sv
// Completion flag and interrupt gating. Assumes finish is a one-cycle
// pulse; a completion outranks a simultaneous clear write.
module sadc_irq_flag
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit0,
    input  logic              finish,
    output logic              raw_q,
    output logic              ien_q,
    output logic              masked
);
    logic clr_hit;

    assign clr_hit = we && (addr == W_CLR) && wbit0;
    assign masked  = raw_q & ien_q;

    // Raw completion flag: set on finish, else cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (finish) begin
            raw_q <= 1'b1;
        end else if (clr_hit) begin
            raw_q <= 1'b0;
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (we && addr == W_IEN) begin
            ien_q <= wbit0;
        end
    end

    assert_finish_sets_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> raw_q);
    assert_raw_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(finish));
endmodule

// File: rtl/sadc_ctl_top.sv
// Top of the converter control block: wires the register file, burst
// sequencer and interrupt flag, and muxes the read word.
// Assumes reads are combinational on bus_addr.
module sadc_ctl_top
    import sadc_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int SCALE_W  = 2,
    parameter int CNT_W    = 4,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                cvt_start,
    output logic [CHAN_W-1:0]   cvt_chan,
    output logic [SCALE_W-1:0]  cvt_scale,
    output logic                cvt_wide,
    input  logic                cvt_done,
    input  logic [SAMPLE_W-1:0] cvt_sample,
    output logic                irq
);
    logic                on_q, run_q, finish, raw_q, ien_q, masked;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] sample_q;

    sadc_cfg_regs #(.CHAN_W(CHAN_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .seq_finish(finish), .on_q(on_q), .run_q(run_q), .wide_q(cvt_wide),
        .cnt_q(cnt_q), .chan_q(cvt_chan), .scale_q(cvt_scale)
    );

    sadc_sequencer #(.CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .on(on_q), .run(run_q), .cnt(cnt_q),
        .cvt_done(cvt_done), .cvt_sample(cvt_sample), .cvt_start(cvt_start),
        .finish(finish), .sample_q(sample_q)
    );

    sadc_irq_flag u_irq (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wbit0(bus_wdata[0]), .finish(finish), .raw_q(raw_q), .ien_q(ien_q),
        .masked(masked)
    );

    assign irq = masked;

    // Read mux: each word returns its own fields, zeros elsewhere.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            W_CTRL: begin
                bus_rdata[B_ON]                = on_q;
                bus_rdata[B_RUN]               = run_q;
                bus_rdata[B_WIDE]              = cvt_wide;
                bus_rdata[B_CNT_LO +: CNT_W]   = cnt_q;
            end
            W_CFG: begin
                bus_rdata[B_CH_LO +: CHAN_W]   = cvt_chan;
                bus_rdata[B_SC_LO +: SCALE_W]  = cvt_scale;
            end
            W_DATA:  bus_rdata[SAMPLE_W-1:0] = sample_q;
            W_IEN:   bus_rdata[0]            = ien_q;
            W_MSK:   bus_rdata[0]            = masked;
            W_RAW:   bus_rdata[0]            = raw_q;
            default: bus_rdata = '0;
        endcase
    end

    assert_irq_follows_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_q);
endmodule

// File: tb/sadc_ctl_top_test.sv
module sadc_ctl_top_test;
    localparam int LAT = 3;
    localparam logic [5:0] A_CTRL = 6'd0, A_CFG = 6'd1, A_DATA = 6'd19,
                           A_IEN = 6'd20, A_CLR = 6'd21, A_MSK = 6'd22, A_RAW = 6'd23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cvt_start, cvt_wide, cvt_done, irq;
    logic [4:0]  cvt_chan;
    logic [1:0]  cvt_scale;
    logic [11:0] cvt_sample;

    logic        m_busy = 1'b0, m_done = 1'b0, stray = 1'b0;
    int          m_lat = 0;
    int          n_starts = 0;
    logic [11:0] m_samp = '0;
    logic [4:0]  last_ch = '0;
    logic [1:0]  last_sc = '0;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    assign cvt_done   = m_done | stray;
    assign cvt_sample = stray ? 12'hABC : m_samp;

    sadc_ctl_top uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cvt_start(cvt_start),
        .cvt_chan(cvt_chan), .cvt_scale(cvt_scale), .cvt_wide(cvt_wide),
        .cvt_done(cvt_done), .cvt_sample(cvt_sample), .irq(irq)
    );

    function automatic logic [11:0] samp(input logic [4:0] ch, input logic [1:0] sc, input int k);
        int v;
        v = int'(ch) * 113 + int'(sc) * 29 + k * 7 + 5;
        return 12'(v % 4096);
    endfunction

    // Behavioural converter: answers each start strobe after LAT+1 cycles.
    always @(posedge clk) begin
        m_done <= 1'b0;
        if (rst_n) begin
            if (m_busy) begin
                if (m_lat == 0) begin
                    m_done <= 1'b1;
                    m_busy <= 1'b0;
                end else begin
                    m_lat <= m_lat - 1;
                end
            end
            if (cvt_start) begin
                m_busy   <= 1'b1;
                m_lat    <= LAT;
                m_samp   <= samp(cvt_chan, cvt_scale, n_starts);
                last_ch  <= cvt_chan;
                last_sc  <= cvt_scale;
                n_starts <= n_starts + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic poll_raw(input string req);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 500; i++) begin
            rd(A_RAW, v);
            if (v[0]) break;
        end
        check(req, v, 32'h1);
    endtask

    // Full software sequence for one burst; checks strobes, fields and sample.
    task automatic convert(input logic [4:0] ch, input logic [1:0] sc, input int n);
        logic [31:0] v;
        int s0;
        wr(A_CTRL, 32'h1);
        wr(A_CLR, 32'h1);
        wr(A_CFG, (32'(sc) << 9) | 32'(ch));
        wr(A_CTRL, 32'h5 | (32'(n) << 4));
        s0 = n_starts;
        wr(A_CTRL, 32'h7 | (32'(n) << 4));
        poll_raw("R7 raw sets at completion");
        check("R5 strobe count n+1", 32'(n_starts - s0), 32'(n + 1));
        check("R4 strobe carries channel and scale", {23'd0, last_sc, 2'd0, last_ch}, {23'd0, sc, 2'd0, ch});
        rd(A_CTRL, v);
        check("R5 run self-clears", v, 32'h5 | (32'(n) << 4));
        rd(A_DATA, v);
        check("R6 sample word", v, {20'd0, samp(ch, sc, n_starts - 1)});
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, d0;
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every word.
        foreach (A_LIST[i]) begin
            rd(A_LIST[i], v);
            check("R1 reset word zero", v, 32'h0);
        end
        check("R1 irq low", {31'd0, irq}, 32'h0);
        check("R1 no strobe", {31'd0, cvt_start}, 32'h0);

        // R2/R3/R4/R8: field readback.
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v);  check("R4 config readback", v, 32'h61F);
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, v); check("R3 control readback", v, 32'hF5);
        check("R3 wide mode pin", {31'd0, cvt_wide}, 32'h1);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); check("R3 control cleared", v, 32'h0);
        check("R3 wide mode pin off", {31'd0, cvt_wide}, 32'h0);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v);  check("R8 enable readback", v, 32'h1);
        wr(A_IEN, 32'h0);
        rd(A_CLR, v);  check("R2 clear word reads zero", v, 32'h0);
        rd(6'd2, v);   check("R2 unmapped word zero", v, 32'h0);

        // R9: run without converter on.
        s = n_starts;
        wr(A_CTRL, 32'h2);
        repeat (10) @(negedge clk);
        check("R9 no strobe when off", 32'(n_starts), 32'(s));
        rd(A_CTRL, v); check("R9 run stays clear", v, 32'h0);

        // R4/R6: every channel and scale, single sample.
        for (int ch = 0; ch < 32; ch++)
            for (int sc = 0; sc < 4; sc++)
                convert(5'(ch), 2'(sc), 0);

        // R5: every repeat count.
        for (int n = 0; n < 16; n++)
            convert(5'd7, 2'd2, n);

        // R8: masking and the interrupt pin; R7 clear.
        rd(A_MSK, v); check("R8 masked low with enable off", v, 32'h0);
        check("R8 irq low with enable off", {31'd0, irq}, 32'h0);
        wr(A_IEN, 32'h1);
        rd(A_MSK, v); check("R8 masked high", v, 32'h1);
        check("R8 irq high", {31'd0, irq}, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); check("R7 clear resets raw", v, 32'h0);
        check("R8 irq drops after clear", {31'd0, irq}, 32'h0);

        // R12: stray done pulse while idle.
        wr(A_CTRL, 32'h1);
        rd(A_DATA, d0);
        @(negedge clk); stray = 1'b1;
        @(negedge clk); stray = 1'b0;
        rd(A_DATA, v); check("R12 stray done keeps sample", v, d0);
        rd(A_RAW, v);  check("R12 stray done keeps raw", v, 32'h0);

        // R10: abort mid-burst.
        wr(A_CFG, (32'd1 << 9) | 32'd3);
        s = n_starts;
        wr(A_CTRL, 32'h1 | (32'd15 << 4) | 32'h2);
        while (n_starts < s + 2) @(negedge clk);
        wr(A_CTRL, 32'h0);
        repeat (2) @(negedge clk);
        s = n_starts;
        rd(A_DATA, d0);
        repeat (40) @(negedge clk);
        check("R10 no strobes after abort", 32'(n_starts), 32'(s));
        rd(A_DATA, v); check("R10 sample frozen after abort", v, d0);
        rd(A_RAW, v);  check("R10 raw stays clear", v, 32'h0);
        rd(A_CTRL, v); check("R10 run cleared", v, 32'h0);

        // R11: clear write in the completion cycle.
        wr(A_CTRL, 32'h1);
        wr(A_CFG, 32'd9);
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        while (!m_done) @(negedge clk);
        bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_RAW, v); check("R11 completion beats clear", v, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); check("R7 later clear works", v, 32'h0);
        wr(A_CTRL, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    localparam logic [5:0] A_LIST [7] = '{A_CTRL, A_CFG, A_DATA, A_IEN, A_CLR, A_MSK, A_RAW};
endmodule